// File: doc/BRIEF.md
# Legacy Prefix Scanner

This block sits at the front of an instruction decoder. It takes the instruction byte stream one byte per cycle, starting at an instruction boundary. Each legacy prefix byte it sees is folded into a set of accumulated attributes: operand and address size overrides, the selected segment, and the LOCK and repeat flags. The first byte that is not a prefix ends the run. In the cycle that byte is accepted, a one-cycle result strobe fires. The strobe carries a copy of that byte as the opcode start, the prefix count and all the accumulated attributes. The scanner then starts clean on the next byte.

Prefixes may come in any order and may repeat. Up to `MAX_PFX` (default fourteen) prefix bytes are accepted on one instruction. One more prefix raises a sticky fault. While the fault is set, the scanner refuses input until `restart` is pulsed. The block reports whether LOCK is present but does not check whether LOCK is legal for the opcode.

Back-pressure rules: a byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while the fault is held or during a `restart` cycle. The result strobe is not back-pressured, so the consumer must take it in the cycle it appears.

Top module: `pfx_scan`

## Requirements
- R1: The bytes F0, F2, F3, 2E, 36, 3E, 26, 64, 65, 66 and 67 are prefixes. Any other accepted byte raises `res_valid` in the same cycle it is accepted, and `res_opcode` carries that byte.
- R2: `res_count` gives the number of prefix bytes accepted since the instruction started. This includes repeated bytes.
- R3: `res_opsz16` is 1 if byte 66 was seen and `res_adsz16` is 1 if byte 67 was seen. Both are 0 otherwise, which means 32-bit.
- R4: `res_seg` encodes the segment override as 0 none, 1 ES (26), 2 CS (2E), 3 SS (36), 4 DS (3E), 5 FS (64), 6 GS (65). When several segment prefixes appear, the last one wins.
- R5: F0 sets `res_lock`, F3 sets `res_rep` and F2 sets `res_repne`. `res_rep` and `res_repne` are never both 1; the later of F2/F3 wins. LOCK combined with a repeat prefix is accepted.
- R6: Repeating a prefix, or changing the order of prefixes from different kinds, changes nothing but the count.
- R7: Up to MAX_PFX prefixes are accepted without fault. Accepting a prefix when MAX_PFX are already counted sets `fault` on the next cycle and drops `in_ready`; no result strobe is produced for that instruction.
- R8: `fault` stays set and input is refused (no strobe) until `restart` is pulsed. `restart` clears the fault, the count and all flags.
- R9: After a result strobe, the count and all flags are clear for the next instruction.
- R10: No state changes in a cycle without an accepted byte or a restart, whatever `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Clears the fault and starts a fresh instruction |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Scanner can accept a byte |
| in_byte | input | 8 | Instruction stream byte |
| res_valid | output | 1 | One-cycle strobe: opcode start byte accepted |
| res_opcode | output | 8 | Copy of the first non-prefix byte |
| res_count | output | CNT_W | Number of prefixes before the opcode |
| res_opsz16 | output | 1 | Operand size override seen |
| res_adsz16 | output | 1 | Address size override seen |
| res_seg | output | 3 | Segment override code (R4) |
| res_lock | output | 1 | LOCK prefix seen |
| res_rep | output | 1 | REP prefix in effect |
| res_repne | output | 1 | REPNE prefix in effect |
| fault | output | 1 | Too many prefixes; held until restart |

## Verification
The checker enforces several rules on every cycle. A strobe only appears with an accepted byte. The two repeat flags are exclusive. The count never passes its limit and grows by one for each counted prefix. A fault blocks input and stays until a restart. After a strobe, state is clear, and with no accepted byte nothing moves. Only the bench's scenarios can show that each prefix byte maps to the right attribute. They also show that the last segment or repeat prefix wins, that fourteen prefixes pass while a fifteenth faults, and that bytes offered while faulted are dropped.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    SEG_NONE = 3'd0,
    SEG_ES   = 3'd1,
    SEG_CS   = 3'd2,
    SEG_SS   = 3'd3,
    SEG_DS   = 3'd4,
    SEG_FS   = 3'd5,
    SEG_GS   = 3'd6
  } seg_e;

  typedef enum logic [2:0] {
    PK_NONE  = 3'd0,
    PK_SEG   = 3'd1,
    PK_OPSZ  = 3'd2,
    PK_ADSZ  = 3'd3,
    PK_LOCK  = 3'd4,
    PK_REP   = 3'd5,
    PK_REPNE = 3'd6
  } pkind_e;

  typedef struct packed {
    logic   is_pfx;
    pkind_e kind;
    seg_e   seg;
  } pclass_t;

  typedef struct packed {
    logic opsz16;
    logic adsz16;
    seg_e seg;
    logic lock;
    logic rep;
    logic repne;
  } pattr_t;

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [7:0] byte_in,
  output pclass_t    cls
);

  always_comb begin
    cls.is_pfx = 1'b1;
    cls.kind   = PK_NONE;
    cls.seg    = SEG_NONE;
    unique case (byte_in)
      8'h26: begin cls.kind = PK_SEG; cls.seg = SEG_ES; end
      8'h2E: begin cls.kind = PK_SEG; cls.seg = SEG_CS; end
      8'h36: begin cls.kind = PK_SEG; cls.seg = SEG_SS; end
      8'h3E: begin cls.kind = PK_SEG; cls.seg = SEG_DS; end
      8'h64: begin cls.kind = PK_SEG; cls.seg = SEG_FS; end
      8'h65: begin cls.kind = PK_SEG; cls.seg = SEG_GS; end
      8'h66: cls.kind = PK_OPSZ;
      8'h67: cls.kind = PK_ADSZ;
      8'hF0: cls.kind = PK_LOCK;
      8'hF2: cls.kind = PK_REPNE;
      8'hF3: cls.kind = PK_REP;
      default: cls.is_pfx = 1'b0;
    endcase
  end

endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  pclass_t          cls,
  output pattr_t           attr,
  output logic [CNT_W-1:0] count
);

  pattr_t           attr_q, attr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    attr_d = attr_q;
    cnt_d  = cnt_q;
    if (clear) begin
      attr_d = '0;
      cnt_d  = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      unique case (cls.kind)
        PK_SEG:   attr_d.seg    = cls.seg;
        PK_OPSZ:  attr_d.opsz16 = 1'b1;
        PK_ADSZ:  attr_d.adsz16 = 1'b1;
        PK_LOCK:  attr_d.lock   = 1'b1;
        PK_REP: begin
          attr_d.rep   = 1'b1;
          attr_d.repne = 1'b0;
        end
        PK_REPNE: begin
          attr_d.repne = 1'b1;
          attr_d.rep   = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      cnt_q  <= '0;
    end else begin
      attr_q <= attr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign attr  = attr_q;
  assign count = cnt_q;

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl #(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  input  logic             is_pfx,
  input  logic [CNT_W-1:0] count,
  output logic             in_ready,
  output logic             take,
  output logic             clear,
  output logic             strobe,
  output logic             fault
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PFX);

  logic fault_q;
  logic accept, full, overflow;

  assign in_ready = !fault_q && !restart;
  assign accept   = in_valid && in_ready;
  assign full     = (count == LIMIT);
  assign take     = accept && is_pfx && !full;
  assign overflow = accept && is_pfx && full;
  assign strobe   = accept && !is_pfx;
  assign clear    = strobe || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (restart)   fault_q <= 1'b0;
    else if (overflow)  fault_q <= 1'b1;
  end

  assign fault = fault_q;

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             res_valid,
  output logic [7:0]       res_opcode,
  output logic [CNT_W-1:0] res_count,
  output logic             res_opsz16,
  output logic             res_adsz16,
  output logic [2:0]       res_seg,
  output logic             res_lock,
  output logic             res_rep,
  output logic             res_repne,
  output logic             fault
);

  pclass_t          cls;
  pattr_t           attr;
  logic [CNT_W-1:0] count;
  logic             take, clear;

  pfx_classify u_cls (
    .byte_in (in_byte),
    .cls     (cls)
  );

  pfx_ctrl #(.MAX_PFX(MAX_PFX), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .in_valid (in_valid),
    .is_pfx   (cls.is_pfx),
    .count    (count),
    .in_ready (in_ready),
    .take     (take),
    .clear    (clear),
    .strobe   (res_valid),
    .fault    (fault)
  );

  pfx_accum #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .take  (take),
    .cls   (cls),
    .attr  (attr),
    .count (count)
  );

  assign res_opcode = in_byte;
  assign res_count  = count;
  assign res_opsz16 = attr.opsz16;
  assign res_adsz16 = attr.adsz16;
  assign res_seg    = attr.seg;
  assign res_lock   = attr.lock;
  assign res_rep    = attr.rep;
  assign res_repne  = attr.repne;

endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             in_valid,
  input logic             in_ready,
  input logic             res_valid,
  input logic [CNT_W-1:0] res_count,
  input logic             res_opsz16,
  input logic             res_adsz16,
  input logic [2:0]       res_seg,
  input logic             res_lock,
  input logic             res_rep,
  input logic             res_repne,
  input logic             fault
);

  logic accept;
  assign accept = in_valid && in_ready;

  AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> accept); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !res_valid && res_count < CNT_W'(MAX_PFX)) |=> res_count == $past(res_count) + 1'b1); // R2
  AST_REP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_rep && res_repne)); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_count <= CNT_W'(MAX_PFX)); // R7
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !in_ready && !res_valid); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !restart) |=> fault); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fault && res_count == '0); // R8
  AST_CLEAN_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> res_count == '0 && res_seg == 3'd0 && !res_opsz16 && !res_adsz16
                  && !res_lock && !res_rep && !res_repne); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !restart) |=> $stable(res_count) && $stable(res_seg) && $stable(fault)
                              && $stable(res_rep) && $stable(res_lock)); // R10

endmodule

bind pfx_scan pfx_scan_chk #(.MAX_PFX(MAX_PFX), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .res_valid  (res_valid),
  .res_count  (res_count),
  .res_opsz16 (res_opsz16),
  .res_adsz16 (res_adsz16),
  .res_seg    (res_seg),
  .res_lock   (res_lock),
  .res_rep    (res_rep),
  .res_repne  (res_repne),
  .fault      (fault)
);

// File: tb/pfx_scan_test.sv
module pfx_scan_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, res_valid, res_opsz16, res_adsz16, res_lock, res_rep, res_repne, fault;
  logic [7:0] res_opcode;
  logic [3:0] res_count;
  logic [2:0] res_seg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfx_scan uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .res_valid(res_valid), .res_opcode(res_opcode), .res_count(res_count),
    .res_opsz16(res_opsz16), .res_adsz16(res_adsz16), .res_seg(res_seg), .res_lock(res_lock),
    .res_rep(res_rep), .res_repne(res_repne), .fault(fault)
  );

  typedef struct packed {
    logic [31:0] pfx;   // first prefix in [31:24]
    logic [2:0]  n;
    logic [7:0]  op;
    logic [3:0]  cnt;
    logic        opsz;
    logic        adsz;
    logic [2:0]  seg;
    logic        lock;
    logic        rep;
    logic        repne;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h00000000, 3'd0, 8'h58, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    '{32'h66000000, 3'd1, 8'h8B, 4'd1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    '{32'h67660000, 3'd2, 8'h8B, 4'd2, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
    '{32'h2E360000, 3'd2, 8'h01, 4'd2, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0},
    '{32'h3E646526, 3'd4, 8'h8B, 4'd4, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
    '{32'hF0F30000, 3'd2, 8'h01, 4'd2, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0},
    '{32'hF3F20000, 3'd2, 8'hA5, 4'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    '{32'hF2F3F02E, 3'd4, 8'hA5, 4'd4, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 1'b0},
    '{32'h67676767, 3'd4, 8'h58, 4'd4, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one byte from a negedge, it is accepted at the following posedge
  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'hF0;
    #1;
  endtask

  task automatic check_result(string req, logic [7:0] op, logic [3:0] cnt, logic opsz, logic adsz,
                              logic [2:0] seg, logic lock, logic rep, logic repne);
    check({req, " strobe"}, {31'd0, res_valid}, 32'd1);
    check({req, " opcode"}, {24'd0, res_opcode}, {24'd0, op});
    check({req, " count"}, {28'd0, res_count}, {28'd0, cnt});
    check({req, " opsz"}, {31'd0, res_opsz16}, {31'd0, opsz});
    check({req, " adsz"}, {31'd0, res_adsz16}, {31'd0, adsz});
    check({req, " seg"}, {29'd0, res_seg}, {29'd0, seg});
    check({req, " lock"}, {31'd0, res_lock}, {31'd0, lock});
    check({req, " rep"}, {31'd0, res_rep}, {31'd0, rep});
    check({req, " repne"}, {31'd0, res_repne}, {31'd0, repne});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R10 reset ready", {31'd0, in_ready}, 32'd1);
    check("R8 reset fault", {31'd0, fault}, 32'd0);
    check("R1 reset strobe", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset count", {28'd0, res_count}, 32'd0);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        send(VEC[v].pfx[31 - 8*i -: 8]);
        check("R1 no strobe on prefix", {31'd0, res_valid}, 32'd0);
      end
      send(VEC[v].op);
      check_result($sformatf("R2/R3/R4/R5/R6 vec%0d", v), VEC[v].op, VEC[v].cnt, VEC[v].opsz,
                   VEC[v].adsz, VEC[v].seg, VEC[v].lock, VEC[v].rep, VEC[v].repne);
    end

    // R9: flags from previous instruction do not leak
    send(8'hF0); send(8'h65); send(8'h66); send(8'h90);
    check_result("R9 loaded", 8'h90, 4'd3, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0);
    send(8'hC3);
    check_result("R9 clean", 8'hC3, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);

    // R10: idle cycles with a prefix value on the bus change nothing
    send(8'hF3);
    idle(); idle(); idle();
    check("R10 idle no strobe", {31'd0, res_valid}, 32'd0);
    check("R10 idle count", {28'd0, res_count}, 32'd1);
    send(8'h90);
    check_result("R10 after idle", 8'h90, 4'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);

    // R7: fourteen prefixes pass
    for (int i = 0; i < 14; i++) send((i % 2) ? 8'h3E : 8'h67);
    check("R7 no fault at 14", {31'd0, fault}, 32'd0);
    send(8'h58);
    check_result("R7 fourteen", 8'h58, 4'd14, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0);

    // R7: fifteenth faults
    for (int i = 0; i < 15; i++) send(8'h67);
    idle();
    check("R7 fault raised", {31'd0, fault}, 32'd1);
    check("R7 ready low", {31'd0, in_ready}, 32'd0);

    // R8: bytes while faulted are refused
    send(8'h58);
    check("R8 no strobe in fault", {31'd0, res_valid}, 32'd0);
    idle(); idle();
    check("R8 fault held", {31'd0, fault}, 32'd1);

    // R8: restart clears
    @(negedge clk);
    in_valid = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    #1;
    check("R8 fault cleared", {31'd0, fault}, 32'd0);
    check("R8 ready back", {31'd0, in_ready}, 32'd1);
    send(8'h58);
    check_result("R8 after restart", 8'h58, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    idle();

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule